// File: doc/BRIEF.md
# High-Side Switch Protection Sequencer

This block is the digital control core of a single-channel high-side power switch. It takes a logic command and a set of asynchronous comparator flags (supply low, supply good, junction hot, junction cooled, current limit active, output open in the off state) plus a strap that disables the cut-off timer. From these it drives a power-stage enable and an active-low diagnostic that a board pulls up through an open drain.

When the power stage has been limiting current for a bounded number of clock cycles, the sequencer shuts it off. It then holds it off for thirty-two times that interval and restarts it automatically if the command is still high. Thermal shutdown overrides both the limitation window and the restart. Supply lockout forces the output off with hysteresis between two comparator levels. An open load seen while the command is low is reported only after it has persisted for a blanking interval, so that ringing after an inductive turn-off is not flagged. All timing is counted in clock cycles and set by parameters.

Top module: `hs_switch_seq`

## Requirements
- R1: During and after reset `pwr_en` is 0 and `diag_n` is 1, and supply lockout is engaged. The output cannot turn on until `uv_good` has been seen high.
- R2: With no fault active, a change on `cmd_in` reaches `pwr_en` on the third rising clock edge after it is applied: two synchronizer stages, then the state register. `diag_n` stays 1.
- R3: If `ilim_flag` stays high while the output is on and the strap is inactive, `pwr_en` stays 1 for exactly TCOFF_CYC cycles in limitation. It then drops to 0, and `diag_n` goes to 0.
- R4: After a cut-off the output is held off with `diag_n` low for 32*TCOFF_CYC cycles. `diag_n` is then released, and one cycle later `pwr_en` returns to 1 if `cmd_in` is still high.
- R5: If `ilim_flag` falls before the limitation window has expired, no cut-off takes place and the output stays on.
- R6: While `cutoff_dis` is high, limitation never leads to a cut-off. The output stays on until `cmd_in` falls.
- R7: A high `tj_hot` forces the output off and `diag_n` low within three edges, even in the middle of a limitation window. The fault remains until `tj_cool` is seen high, even if a restart interval has already expired. `tj_hot` wins over `tj_cool`.
- R8: A high `uv_low` forces the output off regardless of `cmd_in`. When `uv_low` falls, the lockout stays engaged; only a high `uv_good` releases it.
- R9: With `cmd_in` low, `ol_flag` drives `diag_n` low only once it has been high for TBKT_CYC consecutive synchronized cycles. Shorter pulses leave `diag_n` at 1.
- R10: A reported open load clears three edges after `ol_flag` falls. It also clears three edges after `cmd_in` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 1 | Channel on/off command (async) |
| ilim_flag | input | 1 | Current limitation active (async) |
| ol_flag | input | 1 | Output above open-load threshold (async) |
| tj_hot | input | 1 | Junction above shutdown level (async) |
| tj_cool | input | 1 | Junction below shutdown level minus hysteresis (async) |
| uv_low | input | 1 | Supply below turn-off level (async) |
| uv_good | input | 1 | Supply above turn-on level (async) |
| cutoff_dis | input | 1 | Strap: 1 disables the cut-off timer |
| pwr_en | output | 1 | Power-stage enable |
| diag_n | output | 1 | Diagnostic, 0 = fault (cut-off, thermal, open load) |

## Verification
The hardest situation to reach is a thermal trip that lands inside a cut-off restart interval and then clears its hot flag before that interval ends. Only this case shows whether the restart path respects the thermal fault. The bench reaches it by first forcing a cut-off with a sustained limitation flag. It raises and lowers the hot flag while the restart count runs, keeps the cool flag low past the restart point, and only then releases it. A sweep over all combinations of command, thermal and supply flags checks the priority order.

// File: rtl/hss_pkg.sv
package hss_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'd0,
      ST_ON    = 2'd1,
      ST_LIMIT = 2'd2,
      ST_COOL  = 2'd3
   } hss_state_e;

   localparam int unsigned RESTART_SHIFT = 5;
endpackage

// File: rtl/hss_sync.sv
module hss_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hss_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hss_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hss_latch.sv
module hss_latch #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic nxt_o
);
   // set dominates clear
   assign nxt_o = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= nxt_o;
   end
endmodule

// File: rtl/hss_ol_blank.sv
module hss_ol_blank #(
   parameter int unsigned TBKT_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_s,
   input  logic ol_s,
   output logic ol_rep
);
   if (TBKT_CYC < 1) begin : g_bad_tbkt
      $error("hss_ol_blank: TBKT_CYC must be at least 1");
   end

   localparam int unsigned CW = $clog2(TBKT_CYC + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(TBKT_CYC);

   logic          watch;
   logic [CW-1:0] cnt;

   assign watch = ol_s && !cmd_s;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!watch)         cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   assign ol_rep = (cnt == CNT_MAX);

   // R9: a report needs the watch condition in the cycle before
   a_r9_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ol_rep |-> $past(watch));
   // R10: command high removes a report on the next edge
   a_r10_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_s |=> !ol_rep);
endmodule

// File: rtl/hss_core.sv
module hss_core
   import hss_pkg::*;
#(
   parameter int unsigned TCOFF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_s,
   input  logic ilim_s,
   input  logic cdis_s,
   input  logic th_block,
   input  logic uv_block,
   output logic pwr_en,
   output logic cool_active
);
   if (TCOFF_CYC < 1) begin : g_bad_tcoff
      $error("hss_core: TCOFF_CYC must be at least 1");
   end

   localparam int unsigned TRES_CYC = TCOFF_CYC << RESTART_SHIFT;
   localparam int unsigned TW       = $clog2(TRES_CYC);
   localparam logic [TW-1:0] T_LIM  = TW'(TCOFF_CYC - 1);
   localparam logic [TW-1:0] T_RES  = TW'(TRES_CYC - 1);

   hss_state_e    state;
   logic [TW-1:0] timer;
   logic          stop;

   assign stop = !cmd_s || th_block || uv_block;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_OFF;
         timer <= '0;
      end else begin
         case (state)
            ST_OFF: begin
               timer <= '0;
               if (!stop) state <= ST_ON;
            end
            ST_ON: begin
               timer <= '0;
               if (stop)                  state <= ST_OFF;
               else if (ilim_s && !cdis_s) state <= ST_LIMIT;
            end
            ST_LIMIT: begin
               if (stop) begin
                  state <= ST_OFF;
                  timer <= '0;
               end else if (!ilim_s || cdis_s) begin
                  state <= ST_ON;
                  timer <= '0;
               end else if (timer == T_LIM) begin
                  state <= ST_COOL;
                  timer <= '0;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            ST_COOL: begin
               if (uv_block || timer == T_RES) begin
                  state <= ST_OFF;
                  timer <= '0;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            default: begin
               state <= ST_OFF;
               timer <= '0;
            end
         endcase
      end
   end

   assign pwr_en      = (state == ST_ON) || (state == ST_LIMIT);
   assign cool_active = (state == ST_COOL);

   // R3: limitation never outlasts the window
   a_r3_limit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LIMIT) |-> (timer <= T_LIM));
   // R3: cut-off only after the full window
   a_r3_cut_full: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_LIMIT && state == ST_COOL) |-> ($past(timer) == T_LIM));
   // R4: restart interval runs to completion unless supply lockout hits
   a_r4_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_COOL && state == ST_OFF && !$past(uv_block))
         |-> ($past(timer) == T_RES));
   // R6: strap keeps the block out of the limitation window
   a_r6_strap_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LIMIT) |-> !$past(cdis_s));
endmodule

// File: rtl/hs_switch_seq.sv
module hs_switch_seq #(
   parameter int unsigned TCOFF_CYC   = 250,
   parameter int unsigned TBKT_CYC    = 25000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_in,
   input  logic ilim_flag,
   input  logic ol_flag,
   input  logic tj_hot,
   input  logic tj_cool,
   input  logic uv_low,
   input  logic uv_good,
   input  logic cutoff_dis,
   output logic pwr_en,
   output logic diag_n
);
   localparam int unsigned NSYNC = 8;

   logic [NSYNC-1:0] raw, syn;
   logic s_cmd, s_ilim, s_ol, s_hot, s_cool, s_uvl, s_uvok, s_cdis;
   logic th_q, th_nxt, uv_q, uv_nxt;
   logic cool_active, ol_rep;

   assign raw = {cmd_in, ilim_flag, ol_flag, tj_hot, tj_cool, uv_low, uv_good, cutoff_dis};

   hss_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn));

   assign {s_cmd, s_ilim, s_ol, s_hot, s_cool, s_uvl, s_uvok, s_cdis} = syn;

   hss_latch #(.RST_VAL(1'b0)) u_therm (
      .clk(clk), .rst_n(rst_n), .set_i(s_hot), .clr_i(s_cool),
      .q_o(th_q), .nxt_o(th_nxt));

   hss_latch #(.RST_VAL(1'b1)) u_uvlo (
      .clk(clk), .rst_n(rst_n), .set_i(s_uvl), .clr_i(s_uvok),
      .q_o(uv_q), .nxt_o(uv_nxt));

   hss_core #(.TCOFF_CYC(TCOFF_CYC)) u_core (
      .clk(clk), .rst_n(rst_n), .cmd_s(s_cmd), .ilim_s(s_ilim), .cdis_s(s_cdis),
      .th_block(th_nxt), .uv_block(uv_nxt),
      .pwr_en(pwr_en), .cool_active(cool_active));

   hss_ol_blank #(.TBKT_CYC(TBKT_CYC)) u_ol (
      .clk(clk), .rst_n(rst_n), .cmd_s(s_cmd), .ol_s(s_ol), .ol_rep(ol_rep));

   assign diag_n = !(cool_active || th_q || ol_rep);

   // R7: a held thermal fault keeps the stage off
   a_r7_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
      th_q |-> !pwr_en);
   // R8: a held supply lockout keeps the stage off
   a_r8_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
      uv_q |-> !pwr_en);
   // R8: lockout released only by the supply-good flag
   a_r8_release_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(uv_q) |-> $past(s_uvok));
   // R7: thermal released only by the cooled flag
   a_r7_release_needs_cool: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(th_q) |-> $past(s_cool));
endmodule

// File: tb/hs_switch_seq_tb.sv
module hs_switch_seq_tb;
   localparam int unsigned TCOFF = 4;
   localparam int unsigned TBKT  = 6;
   localparam int unsigned TRES  = TCOFF * 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd = 0, ilim = 0, ol = 0, hot = 0, cool = 1, uvl = 0, uvok = 0, cdis = 0;
   logic pwr_en, diag_n;
   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;   // 125 MHz

   hs_switch_seq #(.TCOFF_CYC(TCOFF), .TBKT_CYC(TBKT), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_in(cmd), .ilim_flag(ilim), .ol_flag(ol),
      .tj_hot(hot), .tj_cool(cool), .uv_low(uvl), .uv_good(uvok),
      .cutoff_dis(cdis), .pwr_en(pwr_en), .diag_n(diag_n));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      tick(4);
      chk("R1 reset en", pwr_en, 1'b0);
      chk("R1 reset diag", diag_n, 1'b1);
      rst_n = 1'b1;
      cmd = 1'b1;
      tick(6);
      chk("R1 locked until supply good", pwr_en, 1'b0);

      // R2 latency
      uvok = 1'b1;
      tick(2); chk("R2 not yet on", pwr_en, 1'b0);
      tick(1); chk("R2 on third edge", pwr_en, 1'b1);
      chk("R2 diag released", diag_n, 1'b1);
      cmd = 1'b0;
      tick(2); chk("R2 not yet off", pwr_en, 1'b1);
      tick(1); chk("R2 off third edge", pwr_en, 1'b0);

      // R7 / R8 priority sweep
      for (int c = 0; c < 2; c++)
         for (int h = 0; h < 2; h++)
            for (int l = 0; l < 2; l++) begin
               cmd = c[0]; hot = h[0]; cool = !h[0]; uvl = l[0]; uvok = !l[0];
               tick(4);
               chk("R7 R8 sweep en", pwr_en, c[0] & !h[0] & !l[0]);
               chk("R7 sweep diag", diag_n, !h[0]);
            end
      cmd = 0; hot = 0; cool = 1; uvl = 0; uvok = 1;
      tick(4);

      // R8 hysteresis
      cmd = 1; tick(4);
      chk("R8 on before lockout", pwr_en, 1'b1);
      uvl = 1; uvok = 0;
      tick(3); chk("R8 lockout off", pwr_en, 1'b0);
      uvl = 0;
      tick(8); chk("R8 stays locked between levels", pwr_en, 1'b0);
      uvok = 1;
      tick(2); chk("R8 not yet released", pwr_en, 1'b0);
      tick(1); chk("R8 released by good", pwr_en, 1'b1);

      // R3 / R4 cut-off and restart
      ilim = 1;
      tick(2 + TCOFF); chk("R3 still limiting", pwr_en, 1'b1);
      chk("R3 diag during limit", diag_n, 1'b1);
      tick(1); chk("R3 cut off", pwr_en, 1'b0);
      chk("R3 diag low on cut-off", diag_n, 1'b0);
      ilim = 0;
      tick(TRES - 1);
      chk("R4 held off", pwr_en, 1'b0);
      chk("R4 diag held", diag_n, 1'b0);
      tick(1); chk("R4 diag released", diag_n, 1'b1);
      chk("R4 still off", pwr_en, 1'b0);
      tick(1); chk("R4 restarted", pwr_en, 1'b1);

      // R5 short limitation
      ilim = 1; tick(TCOFF); ilim = 0;
      tick(20);
      chk("R5 no cut-off en", pwr_en, 1'b1);
      chk("R5 no cut-off diag", diag_n, 1'b1);

      // R6 strap
      cdis = 1; tick(3); ilim = 1;
      tick(3 + TCOFF + 10);
      chk("R6 strap keeps on", pwr_en, 1'b1);
      chk("R6 strap diag", diag_n, 1'b1);
      cmd = 0; tick(3);
      chk("R6 off by command", pwr_en, 1'b0);
      ilim = 0; cdis = 0; tick(4);

      // R7 thermal mid-window
      cmd = 1; tick(4);
      ilim = 1; tick(3);
      hot = 1; cool = 0;
      tick(3);
      chk("R7 thermal beats window", pwr_en, 1'b0);
      chk("R7 thermal diag", diag_n, 1'b0);
      ilim = 0; hot = 0;
      tick(20);
      chk("R7 held until cool", pwr_en, 1'b0);
      chk("R7 diag held", diag_n, 1'b0);
      cool = 1;
      tick(2); chk("R7 not yet back", pwr_en, 1'b0);
      tick(1); chk("R7 back on", pwr_en, 1'b1);
      chk("R7 diag released", diag_n, 1'b1);

      // R7 thermal during restart interval
      ilim = 1;
      tick(3 + TCOFF);
      chk("R3 cut-off before thermal", pwr_en, 1'b0);
      ilim = 0; hot = 1; cool = 0;
      tick(5); hot = 0;
      tick(TRES + 10);
      chk("R7 no restart while hot latched", pwr_en, 1'b0);
      chk("R7 diag after restart point", diag_n, 1'b0);
      cool = 1;
      tick(3);
      chk("R7 restart after cool", pwr_en, 1'b1);
      chk("R7 diag after cool", diag_n, 1'b1);

      // R9 / R10 open load
      cmd = 0; tick(4);
      ol = 1; tick(TBKT - 1); ol = 0;
      begin
         logic seen_low = 1'b0;
         for (int k = 0; k < TBKT + 4; k++) begin
            tick(1);
            if (diag_n !== 1'b1) seen_low = 1'b1;
         end
         chk("R9 short pulse ignored", seen_low, 1'b0);
      end
      ol = 1;
      tick(1 + TBKT); chk("R9 still blanked", diag_n, 1'b1);
      tick(1); chk("R9 reported", diag_n, 1'b0);
      chk("R9 output off", pwr_en, 1'b0);
      ol = 0;
      tick(2); chk("R10 not yet clear", diag_n, 1'b0);
      tick(1); chk("R10 clear on reconnect", diag_n, 1'b1);
      ol = 1;
      tick(TBKT + 3); chk("R9 reported again", diag_n, 1'b0);
      cmd = 1;
      tick(2); chk("R10 still reported", diag_n, 1'b0);
      tick(1); chk("R10 clear on command", diag_n, 1'b1);
      chk("R10 on with flag", pwr_en, 1'b1);
      ol = 0;
      tick(4);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule